// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 interrupt inputs from peripherals. It drives one active-low request line toward a processor. Every source has its own control word with two fields: a trigger type (high level, low level, rising edge or falling edge) and a 3-bit priority. Software switches sources on and off through two write-one command words, one that sets enable bits and one that clears them. It can read the combined enable state back at any time.

Among the sources that are both pending and enabled, the controller picks the one with the largest priority value. When priorities are equal, the lowest source number wins. The processor reads the vector word to learn which source was picked, as the source number times four. That read acknowledges the request: the request line goes high on the next cycle and the controller enters service. It raises no new request until software writes any value to the end-of-service word. Edge-type sources hold a latched pending bit until their own vector is read. Level-type sources are pending only while their input sits at the active level. All inputs pass through a synchronizer before use.

Top module: `pic_top`

## Requirements
- R1: After reset, irq_n_o is 1, the enable word (read at 0x114) is 0, and every source control word (read at byte offset 4*n) is 0.
- R2: A write to byte offset 4*n (n from 0 to 31) stores bits 7:6 as the trigger type (0 low level, 1 high level, 2 falling edge, 3 rising edge) and bits 2:0 as the priority. A read of that offset returns these two fields in place, with every other bit 0.
- R3: A write to 0x120 sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged. The enable word reads back at 0x114 with bit n for source n.
- R4: A write to 0x124 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R5: irq_n_o goes low only while no source is in service and at least one enabled source is pending. A disabled source never pulls it low.
- R6: A read of 0x10C returns 4 times the number of the winning source. The winner is the largest priority value, and on a tie the lowest source number.
- R7: A read of 0x10C while a source is pending and enabled puts the controller in service. irq_n_o is 1 from the next cycle and stays 1 until end of service.
- R8: Any write to 0x130 ends service. If an enabled source is still pending, irq_n_o goes low again.
- R9: A high-level source is pending only while its input is 1, and a low-level source only while its input is 0.
- R10: A rising-edge or falling-edge source latches pending on that edge of its synchronized input. The latch holds after the input returns and clears when a read of 0x10C selects that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Asynchronous interrupt inputs, bit n is source n |
| addr_i | input | 12 | Register byte address |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read; qualifies read side effects |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, valid in the same cycle |
| irq_n_o | output | 1 | Active-low interrupt request to the processor |

## Verification
The assertions assume that a bus cycle is either a read or a write, never both, and that addresses are word aligned. The edge-latch check assumes that a source's trigger type does not change while its latch is set. The bench uses one task per bus access, so each access has its own cycle. It reprograms a source only after that source is disabled and its latch has been cleared. It also keeps rising-edge inputs low until they are configured, so that the synchronizer's reset value of 0 creates no false edge.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

    localparam int OFS_VECTOR  = 'h10C;
    localparam int OFS_ENABLES = 'h114;
    localparam int OFS_EN_SET  = 'h120;
    localparam int OFS_EN_CLR  = 'h124;
    localparam int OFS_EOS     = 'h130;

endpackage

// File: rtl/pic_src_cond.sv
module pic_src_cond
    import pic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_i,
    input  trig_e trig_i,
    input  logic  clr_i,
    output logic  pend_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   latch;
    } cond_t;

    cond_t st_d, st_q;
    logic  s_now, hit;

    always_comb begin
        st_d      = st_q;
        s_now     = st_q.sync[SYNC_STAGES-1];
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], in_i};
        st_d.prev = s_now;
        hit = ((trig_i == TRIG_RISE) && s_now && !st_q.prev) ||
              ((trig_i == TRIG_FALL) && !s_now && st_q.prev);
        if (hit)
            st_d.latch = 1'b1;
        else if (clr_i || !trig_i[1])
            st_d.latch = 1'b0;
        case (trig_i)
            TRIG_HIGH: pend_o = s_now;
            TRIG_LOW:  pend_o = !s_now;
            default:   pend_o = st_q.latch;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: a latched edge survives until its own acknowledge
    assert_edge_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latch && !clr_i && trig_i[1]) |=> st_q.latch);

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] elig_i,
    input  logic [PRIO_W-1:0] prio_i [NUM_SRC],
    output logic              any_o,
    output logic [ID_W-1:0]   sel_o
);

    logic [PRIO_W-1:0] best;

    always_comb begin
        any_o = 1'b0;
        sel_o = '0;
        best  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig_i[i] && (!any_o || prio_i[i] > best)) begin
                any_o = 1'b1;
                sel_o = ID_W'(i);
                best  = prio_i[i];
            end
        end
    end

    // R6: the chosen source is eligible, and a choice exists whenever any source is eligible
    assert_winner_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> elig_i[sel_o]);
    assert_any_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_o == (|elig_i));

endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int PRIO_W      = 3,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic               irq_n_o
);

    localparam int ID_W = $clog2(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0][1:0]        trig;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_SRC-1:0]             enables;
        logic                           in_svc;
        logic                           irq;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NUM_SRC-1:0] pend, elig, clr;
    logic [PRIO_W-1:0]  prio_arr [NUM_SRC];
    logic               any;
    logic [ID_W-1:0]    sel;
    logic               ctrl_hit, ack, eos;
    logic [ID_W-1:0]    idx;

    assign ctrl_hit = (addr_i < ADDR_W'(NUM_SRC * 4)) && (addr_i[1:0] == 2'b00);
    assign idx      = addr_i[ID_W+1:2];
    assign ack      = rd_en_i && (addr_i == ADDR_W'(OFS_VECTOR)) && any;
    assign eos      = wr_en_i && (addr_i == ADDR_W'(OFS_EOS));
    assign elig     = pend & st_q.enables;
    assign irq_n_o  = !st_q.irq;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign prio_arr[g] = st_q.prio[g];
        assign clr[g]      = ack && (sel == ID_W'(g));
        pic_src_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_i   (src_i[g]),
            .trig_i (trig_e'(st_q.trig[g])),
            .clr_i  (clr[g]),
            .pend_o (pend[g])
        );
    end

    pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .elig_i (elig),
        .prio_i (prio_arr),
        .any_o  (any),
        .sel_o  (sel)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i && ctrl_hit) begin
            st_d.trig[idx] = wdata_i[7:6];
            st_d.prio[idx] = wdata_i[PRIO_W-1:0];
        end
        if (wr_en_i && addr_i == ADDR_W'(OFS_EN_SET))
            st_d.enables = st_q.enables | wdata_i[NUM_SRC-1:0];
        if (wr_en_i && addr_i == ADDR_W'(OFS_EN_CLR))
            st_d.enables = st_q.enables & ~wdata_i[NUM_SRC-1:0];
        if (ack)
            st_d.in_svc = 1'b1;
        else if (eos)
            st_d.in_svc = 1'b0;
        st_d.irq = !st_q.in_svc && any && !ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (ctrl_hit) begin
            rdata_o[7:6]        = st_q.trig[idx];
            rdata_o[PRIO_W-1:0] = st_q.prio[idx];
        end else if (addr_i == ADDR_W'(OFS_VECTOR)) begin
            rdata_o[ID_W+1:2] = sel;
        end else if (addr_i == ADDR_W'(OFS_ENABLES)) begin
            rdata_o[NUM_SRC-1:0] = st_q.enables;
        end
    end

    // R3 / R4: command writes touch only the selected enable bits
    assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFS_EN_SET)) |=>
            ((st_q.enables & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));
    assert_enable_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFS_EN_CLR)) |=>
            ((st_q.enables & $past(wdata_i[NUM_SRC-1:0])) == '0));
    // R7: no request while in service, and no request may coexist with service
    assert_quiet_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.in_svc |=> irq_n_o);
    assert_req_excludes_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> !st_q.in_svc);
    // R5: a request is only raised for something that was eligible
    assert_req_needs_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> $past(any));

endmodule

// File: tb/sim_pic_top.sv
module sim_pic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_n;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pic_top u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
        .rdata_o(rdata), .irq_n_o(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cleanup();
        wr(12'h124, 32'hFFFF_FFFF);
        wr(12'h130, 32'h0);
        src = '0;
        idle(4);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_n", {31'b0, irq_n}, 32'h1);
        rd(12'h114, d); chk("R1 enables", d, 32'h0);
        rd(12'h014, d); chk("R1 ctrl5", d, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        wr(12'h00C, 32'hFFFF_FFFF);
        rd(12'h00C, d); chk("R2 ctrl3 fields", d, 32'h0000_00C7);
        wr(12'h07C, 32'h0000_0045);
        rd(12'h07C, d); chk("R2 ctrl31", d, 32'h0000_0045);
        for (int i = 0; i < 32; i++) wr(12'(i * 4), 32'h40);
        rd(12'h00C, d); chk("R2 ctrl3 rewritten", d, 32'h0000_0040);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(12'h120, 32'h0000_00F0);
        wr(12'h120, 32'h0000_0003);
        rd(12'h114, d); chk("R3 set accumulates", d, 32'h0000_00F3);
        wr(12'h124, 32'h0000_0021);
        rd(12'h114, d); chk("R4 clear selective", d, 32'h0000_00D2);
        cleanup();
        src[7] = 1'b1;
        idle(6);
        chk("R5 disabled source quiet", {31'b0, irq_n}, 32'h1);
        cleanup();
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(12'h010, 32'h42);
        wr(12'h120, 32'h10);
        src[4] = 1'b1; idle(4);
        chk("R5 enabled high level requests", {31'b0, irq_n}, 32'h0);
        src[4] = 1'b0; idle(4);
        chk("R9 high level released", {31'b0, irq_n}, 32'h1);
        wr(12'h018, 32'h01);
        wr(12'h120, 32'h40);
        idle(3);
        chk("R9 low level requests", {31'b0, irq_n}, 32'h0);
        rd(12'h10C, d); chk("R6 vector low level", d, 32'd24);
        chk("R7 ack releases", {31'b0, irq_n}, 32'h1);
        wr(12'h130, 32'h0); idle(2);
        chk("R8 re-request after eos", {31'b0, irq_n}, 32'h0);
        rd(12'h10C, d);
        src[6] = 1'b1;
        wr(12'h130, 32'h0); idle(5);
        chk("R9 low level released", {31'b0, irq_n}, 32'h1);
        cleanup();
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(12'h024, 32'h45);
        wr(12'h030, 32'h45);
        wr(12'h008, 32'h43);
        src[9] = 1'b1; src[12] = 1'b1; src[2] = 1'b1;
        idle(4);
        wr(12'h120, 32'h0000_1204);
        rd(12'h10C, d); chk("R6 tie to lowest number", d, 32'd36);
        wr(12'h130, 32'h0);
        wr(12'h124, 32'h0000_0200);
        rd(12'h10C, d); chk("R6 next equal priority", d, 32'd48);
        wr(12'h130, 32'h0);
        wr(12'h124, 32'h0000_1000);
        rd(12'h10C, d); chk("R6 lower priority last", d, 32'd8);
        wr(12'h130, 32'h0);
        cleanup();
    endtask

    task automatic t_edge();
        logic [31:0] d;
        src[21] = 1'b1; idle(4);
        wr(12'h050, 32'hC4);
        wr(12'h054, 32'h84);
        wr(12'h120, 32'h0030_0000);
        idle(3);
        chk("R10 no edge no request", {31'b0, irq_n}, 32'h1);
        src[20] = 1'b1; idle(3); src[20] = 1'b0; idle(5);
        chk("R10 rising latched", {31'b0, irq_n}, 32'h0);
        rd(12'h10C, d); chk("R10 rising vector", d, 32'd80);
        wr(12'h130, 32'h0); idle(4);
        chk("R10 rising latch cleared", {31'b0, irq_n}, 32'h1);
        src[21] = 1'b0; idle(6);
        chk("R10 falling latched", {31'b0, irq_n}, 32'h0);
        rd(12'h10C, d); chk("R10 falling vector", d, 32'd84);
        wr(12'h130, 32'h0); idle(4);
        chk("R10 falling latch cleared", {31'b0, irq_n}, 32'h1);
        cleanup();
    endtask

    task automatic t_service();
        logic [31:0] d;
        wr(12'h010, 32'h42);
        src[4] = 1'b1;
        wr(12'h120, 32'h10);
        idle(4);
        chk("R5 request raised", {31'b0, irq_n}, 32'h0);
        rd(12'h10C, d); chk("R6 vector src4", d, 32'd16);
        idle(6);
        chk("R7 held off in service", {31'b0, irq_n}, 32'h1);
        wr(12'h130, 32'hDEAD_BEEF); idle(2);
        chk("R8 any eos data resumes", {31'b0, irq_n}, 32'h0);
        rd(12'h10C, d);
        cleanup();
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_ctrl();
        t_mask();
        t_level();
        t_prio();
        t_edge();
        t_service();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule